// File: doc/BRIEF.md
# Boot Voltage Soft-Start Sequencer

This block sets the start-up voltage for two supply planes that share one reference. It drives an 8-bit code to a DAC. It reads a mode pin and two strap pins, `strap_a` and `strap_b`, and looks up a boot target in one of two tables. When enable rises, it latches that target. It then raises the reference code one LSB at a time at a fixed pace, and reports power good once the code reaches the target.

When enable is lost, power good drops and the code steps back down to zero at the same pace. If enable returns while the code is still falling, the ramp turns around and climbs from wherever the code is. Once power good is high, a rising system power-ok input moves the block into a state where it is ready for later serial voltage commands. The `cmd_ready` output reports that state.

The code has an LSB of 6.25 mV, so a voltage of V volts is code V/0.00625. Enable and power-ok are asynchronous. Each one passes through a synchronizer and a rising-edge detector before the state machine acts on it.

Top module: `bss_seq`

## Requirements
- R1: While `rst` is high, and on the first cycles after it falls with enable low, `ref_code` is 0 and `pgood` and `cmd_ready` are 0.
- R2: With `fix_mode` low, the strap pair {strap_a,strap_b} selects the boot target: 00 gives 176 (1.1 V), 01 gives 160 (1.0 V), 10 gives 144 (0.9 V) and 11 gives 128 (0.8 V). Once power good is reached, `ref_code` equals that value.
- R3: With `fix_mode` high, {strap_a,strap_b} selects the target: 00 gives 224 (1.4 V), 01 gives 192 (1.2 V), 10 gives 160 (1.0 V) and 11 gives 128 (0.8 V).
- R4: With `fix_mode` low, the target is captured when enable rises. Strap changes after that point have no effect on the code reached.
- R5: With `fix_mode` high and enable held, a strap change updates the target. `ref_code` then steps to the new value at the ramp pace, and `pgood` stays high throughout.
- R6: The reference ramps in steps of one LSB, and consecutive steps are exactly STEP_CYC cycles apart. Suppose `en_in` rises between two clock edges and the code starts at 0. Then the first step appears after the (3+STEP_CYC)th rising edge and `pgood` rises after the (4+target*STEP_CYC)th edge.
- R7: `pgood` is never high while `ref_code` differs from the target during the start-up ramp.
- R8: When `en_in` falls, `pgood` is low after the third rising edge. `ref_code` steps down at the same pace and reaches 0 after the (3+target*STEP_CYC)th edge.
- R9: If enable rises again while the code is ramping down, the code climbs from its present value without first returning to zero, and `pgood` rises again at the target.
- R10: A rise of `sys_ok_in` while `pgood` is high raises `cmd_ready` after the third rising edge. A rise that happens while `pgood` is low is ignored. A fall of `sys_ok_in` clears `cmd_ready` while `pgood` stays high. Loss of enable clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fix_mode | input | 1 | Table select: 0 boot table, 1 fixed-voltage table |
| strap_a | input | 1 | Strap input, upper bit of the table index |
| strap_b | input | 1 | Strap input, lower bit of the table index |
| en_in | input | 1 | Asynchronous enable |
| sys_ok_in | input | 1 | Asynchronous system power-ok |
| ref_code | output | 8 | Reference code to the DAC, 6.25 mV per LSB |
| pgood | output | 1 | Power good: ramp complete and enable held |
| cmd_ready | output | 1 | Ready for serial voltage commands |

## Verification
The assertions check several rules on every cycle:
- the code never moves by more than one LSB per clock;
- the code is zero whenever the block is off;
- power good first rises with the code equal to the latched target;
- a low synchronized enable is followed by power good low;
- `cmd_ready` never stands without power good;
- in boot mode, the target holds except at an enable rise.

Only the bench scenarios can show the rest:
- the exact step spacing and the start-up and shut-down latencies;
- the table values;
- that straps changed mid-ramp are ignored;
- that a reversed ramp never touches zero;
- that a power-ok rise seen before power good is ignored.

// File: rtl/bss_pkg.sv
`timescale 1ns/1ps
package bss_pkg;

    localparam int CODE_W = 8;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RAMP_UP,
        ST_REGULATE,
        ST_CMD_READY,
        ST_RAMP_DOWN
    } seq_state_t;

    typedef struct packed {
        logic lvl;
        logic rise;
    } sync_out_t;

    // 6.25 mV per LSB: code = mV * 4 / 25
    function automatic code_t mv_to_code(input int unsigned mv);
        int unsigned c;
        c = (mv * 4) / 25;
        return c[CODE_W-1:0];
    endfunction

    function automatic code_t boot_target(input logic [1:0] sel);
        code_t r;
        case (sel)
            2'b00:   r = mv_to_code(1100);
            2'b01:   r = mv_to_code(1000);
            2'b10:   r = mv_to_code(900);
            default: r = mv_to_code(800);
        endcase
        return r;
    endfunction

    function automatic code_t fixed_target(input logic [1:0] sel);
        code_t r;
        case (sel)
            2'b00:   r = mv_to_code(1400);
            2'b01:   r = mv_to_code(1200);
            2'b10:   r = mv_to_code(1000);
            default: r = mv_to_code(800);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bss_sync.sv
`timescale 1ns/1ps
module bss_sync #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                d,
    output bss_pkg::sync_out_t  o
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign o.lvl  = chain[STAGES-1];
    assign o.rise = chain[STAGES-1] & ~last;

    // R6: an edge pulse lasts exactly one cycle
    a_r6_rise_one_cycle: assert property (@(posedge clk) disable iff (rst)
        o.rise |=> !o.rise);
endmodule

// File: rtl/bss_decode.sv
`timescale 1ns/1ps
module bss_decode (
    input  logic           fix_mode,
    input  logic [1:0]     strap,
    output bss_pkg::code_t target
);
    always_comb begin
        if (fix_mode) target = bss_pkg::fixed_target(strap);
        else          target = bss_pkg::boot_target(strap);
    end
endmodule

// File: rtl/bss_ramp.sv
`timescale 1ns/1ps
module bss_ramp #(
    parameter int STEP_CYC = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           restart,
    input  logic           move_en,
    input  bss_pkg::code_t goal,
    output bss_pkg::code_t code,
    output logic           at_goal
);
    localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign at_goal = (code == goal);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            code <= '0;
        end else if (restart || !move_en || at_goal) begin
            cnt  <= '0;
        end else if (cnt == CNT_LAST) begin
            cnt  <= '0;
            code <= (code < goal) ? code + 1'b1 : code - 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R6: the code moves at most one LSB per clock
    a_r6_single_lsb: assert property (@(posedge clk) disable iff (rst)
        (code == $past(code)) || (code == $past(code) + 8'd1) || (code == $past(code) - 8'd1));
endmodule

// File: rtl/bss_seq.sv
`timescale 1ns/1ps
module bss_seq #(
    parameter int STEP_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fix_mode,
    input  logic                         strap_a,
    input  logic                         strap_b,
    input  logic                         en_in,
    input  logic                         sys_ok_in,
    output logic [bss_pkg::CODE_W-1:0]   ref_code,
    output logic                         pgood,
    output logic                         cmd_ready
);
    import bss_pkg::*;

    sync_out_t  en_s, ok_s;
    code_t      dec_tgt, tgt_q, goal, code;
    logic       at_goal, restart, move_en, tgt_load;
    seq_state_t st_q, st_n;

    bss_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
        .clk(clk), .rst(rst), .d(en_in), .o(en_s));

    bss_sync #(.STAGES(SYNC_STAGES)) u_ok_sync (
        .clk(clk), .rst(rst), .d(sys_ok_in), .o(ok_s));

    bss_decode u_dec (
        .fix_mode(fix_mode), .strap({strap_a, strap_b}), .target(dec_tgt));

    always_comb begin
        st_n = st_q;
        case (st_q)
            ST_OFF:       if (en_s.rise) st_n = ST_RAMP_UP;
            ST_RAMP_UP: begin
                if (!en_s.lvl)    st_n = ST_RAMP_DOWN;
                else if (at_goal) st_n = ST_REGULATE;
            end
            ST_REGULATE: begin
                if (!en_s.lvl)     st_n = ST_RAMP_DOWN;
                else if (ok_s.rise) st_n = ST_CMD_READY;
            end
            ST_CMD_READY: begin
                if (!en_s.lvl)     st_n = ST_RAMP_DOWN;
                else if (!ok_s.lvl) st_n = ST_REGULATE;
            end
            ST_RAMP_DOWN: begin
                if (en_s.rise)      st_n = ST_RAMP_UP;
                else if (code == '0) st_n = ST_OFF;
            end
            default:      st_n = ST_OFF;
        endcase
    end

    // target load: on an enable rise, or continuously in fixed mode while enabled
    always_comb begin
        tgt_load = 1'b0;
        if ((st_q == ST_OFF || st_q == ST_RAMP_DOWN) && en_s.rise)
            tgt_load = 1'b1;
        else if (fix_mode && en_s.lvl &&
                 (st_q == ST_RAMP_UP || st_q == ST_REGULATE || st_q == ST_CMD_READY))
            tgt_load = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_OFF;
            tgt_q <= '0;
        end else begin
            st_q <= st_n;
            if (tgt_load) tgt_q <= dec_tgt;
        end
    end

    assign restart = (st_n != st_q);
    assign move_en = (st_q != ST_OFF);
    assign goal    = (st_q == ST_RAMP_DOWN) ? '0 : tgt_q;

    bss_ramp #(.STEP_CYC(STEP_CYC)) u_ramp (
        .clk(clk), .rst(rst), .restart(restart), .move_en(move_en),
        .goal(goal), .code(code), .at_goal(at_goal));

    assign ref_code  = code;
    assign pgood     = (st_q == ST_REGULATE) || (st_q == ST_CMD_READY);
    assign cmd_ready = (st_q == ST_CMD_READY);

    // R1: code is zero whenever the block is off
    a_r1_off_zero: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OFF) |-> (ref_code == '0));

    // R7: power good first appears with the code on target
    a_r7_pgood_on_target: assert property (@(posedge clk) disable iff (rst)
        $rose(pgood) |-> (ref_code == tgt_q));

    // R8: a low synchronized enable removes power good next cycle
    a_r8_enable_loss: assert property (@(posedge clk) disable iff (rst)
        !en_s.lvl |=> !pgood);

    // R10: command-ready never stands without power good
    a_r10_ready_needs_pgood: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> pgood);

    // R4: in boot mode the target holds except at an enable rise
    a_r4_boot_hold: assert property (@(posedge clk) disable iff (rst)
        (!fix_mode && !en_s.rise) |=> $stable(tgt_q));
endmodule

// File: tb/bss_seq_tb_top.sv
`timescale 1ns/1ps
module bss_seq_tb_top;
    localparam int STEP = 4;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fix_mode = 1'b0, strap_a = 1'b0, strap_b = 1'b0;
    logic en_in = 1'b0, sys_ok_in = 1'b0;
    logic [7:0] ref_code;
    logic pgood, cmd_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bss_seq #(.STEP_CYC(STEP), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .fix_mode(fix_mode), .strap_a(strap_a),
        .strap_b(strap_b), .en_in(en_in), .sys_ok_in(sys_ok_in),
        .ref_code(ref_code), .pgood(pgood), .cmd_ready(cmd_ready));

    function automatic int exp_code(input bit mode, input bit [1:0] s);
        int mv;
        if (mode) mv = (s == 2'd0) ? 1400 : (s == 2'd1) ? 1200 : (s == 2'd2) ? 1000 : 800;
        else      mv = (s == 2'd0) ? 1100 : (s == 2'd1) ? 1000 : (s == 2'd2) ? 900  : 800;
        return (mv * 1000) / 6250;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_straps(input bit [1:0] s);
        strap_a = s[1];
        strap_b = s[0];
    endtask

    // start from code 0; optional strap flip mid-ramp (boot mode)
    task automatic power_up(input bit mode, input bit [1:0] s, input bit flip);
        int n = 0, prev, last = 0, first_at = 0, gap_bad = 0, early = 0, tgt;
        tgt = exp_code(mode, s);
        @(negedge clk);
        fix_mode = mode;
        set_straps(s);
        en_in = 1'b1;
        prev = ref_code;
        while (n < 4000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (int'(ref_code) != prev) begin
                if (first_at == 0) first_at = n;
                else if (n - last != STEP) gap_bad++;
                last = n;
                prev = ref_code;
            end
            if (pgood && int'(ref_code) != tgt) early++;
            if (flip && n == 10) set_straps(~s);
            if (pgood) break;
        end
        chk("R6", "first step edge", first_at, 3 + STEP);
        chk("R6", "step gaps off pace", gap_bad, 0);
        chk("R6", "pgood edge", n, 4 + tgt * STEP);
        chk("R7", "pgood before target", early, 0);
        if (flip)      chk("R4", "code after strap flip", ref_code, tgt);
        else if (mode) chk("R3", "fixed table code", ref_code, tgt);
        else           chk("R2", "boot table code", ref_code, tgt);
        if (flip) set_straps(s);
    endtask

    task automatic power_down(input int tgt);
        int n = 0, fall_at = 0;
        @(negedge clk);
        en_in = 1'b0;
        while (n < 4000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (!pgood && fall_at == 0) fall_at = n;
            if (ref_code == 8'd0) break;
        end
        chk("R8", "pgood fall edge", fall_at, 3);
        chk("R8", "code zero edge", n, 3 + tgt * STEP);
        chk("R10", "cmd_ready after enable loss", cmd_ready, 0);
    endtask

    task automatic ok_rise_check(input int exp_edge);
        int n = 0;
        @(negedge clk);
        sys_ok_in = 1'b1;
        while (n < 10) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (cmd_ready) break;
        end
        chk("R10", "cmd_ready edge", n, exp_edge);
    endtask

    initial begin
        #(WATCHDOG * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        chk("R1", "code in reset", ref_code, 0);
        chk("R1", "pgood in reset", pgood, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "code after reset", ref_code, 0);
        chk("R1", "pgood after reset", pgood, 0);
        chk("R1", "cmd_ready after reset", cmd_ready, 0);

        // both tables, every strap value
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                power_up(m[0], s[1:0], 1'b0);
                power_down(exp_code(m[0], s[1:0]));
            end
        end

        // R4: boot target held despite strap change mid-ramp
        power_up(1'b0, 2'b01, 1'b1);
        power_down(exp_code(1'b0, 2'b01));

        // R5: fixed mode follows strap changes with pgood held
        begin
            int lowpg = 0, n = 0;
            power_up(1'b1, 2'b00, 1'b0);
            @(negedge clk);
            set_straps(2'b11);
            while (n < 2000 && ref_code != 8'd128) begin
                @(posedge clk); n++;
                @(negedge clk);
                if (!pgood) lowpg++;
            end
            chk("R5", "code after fixed strap drop", ref_code, 128);
            set_straps(2'b01);
            n = 0;
            while (n < 2000 && ref_code != 8'd192) begin
                @(posedge clk); n++;
                @(negedge clk);
                if (!pgood) lowpg++;
            end
            chk("R5", "code after fixed strap raise", ref_code, 192);
            chk("R5", "pgood low cycles during move", lowpg, 0);
            power_down(192);
        end

        // R10: ready after pgood, cleared by power-ok fall, cleared by enable loss
        power_up(1'b0, 2'b10, 1'b0);
        ok_rise_check(3);
        @(negedge clk);
        sys_ok_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", "cmd_ready after power-ok fall", cmd_ready, 0);
        chk("R10", "pgood after power-ok fall", pgood, 1);
        ok_rise_check(3);
        power_down(exp_code(1'b0, 2'b10));
        // power-ok already high before pgood: ignored
        power_up(1'b0, 2'b11, 1'b0);
        repeat (20) @(negedge clk);
        chk("R10", "cmd_ready from early power-ok", cmd_ready, 0);
        sys_ok_in = 1'b0;
        power_down(128);

        // R9: re-enable while ramping down
        begin
            int n = 0, minc = 255, mid;
            power_up(1'b0, 2'b00, 1'b0);
            @(negedge clk);
            en_in = 1'b0;
            repeat (3 + 20 * STEP) @(negedge clk);
            mid = ref_code;
            chk("R9", "code mid ramp-down", mid, 176 - 20);
            en_in = 1'b1;
            while (n < 2000 && !pgood) begin
                @(posedge clk); n++;
                @(negedge clk);
                if (int'(ref_code) < minc) minc = ref_code;
            end
            chk("R9", "no return to zero", (minc >= mid - 2) ? 1 : 0, 1);
            chk("R9", "code after recovery", ref_code, 176);
            power_down(176);
        end

        // constrained random runs
        for (int i = 0; i < 6; i++) begin
            bit m, fl, ok;
            bit [1:0] s;
            m  = 1'($urandom % 2);
            s  = 2'($urandom % 4);
            fl = !m && (($urandom % 2) == 1);
            ok = ($urandom % 2) == 1;
            power_up(m, s, fl);
            if (ok) begin
                ok_rise_check(3);
            end
            power_down(exp_code(m, s));
            sys_ok_in = 1'b0;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule